// File: doc/BRIEF.md
# Banked Shader Register Store

This block is the operand storage of a multithreaded shader core. It keeps temporaries, outputs and attributes in sixteen banks. Each bank has 128 registers of 32 bits, and each bank can do one read and one write per cycle. The instruction side issues an operand read by bank and register index. The value comes back on the following cycle together with a valid flag.

Results from the ALU are not written straight into the banks. They enter a small write-back queue. The oldest entry commits only in a cycle where its bank is not being read, so a read always wins a bank clash. A read that names a register still waiting in the queue gets the newest queued value by forwarding, so stale data never reaches the reader.

A second request port lets the instruction side fetch one source operand of the next instruction ahead of time. That operand sits in a one-entry tagged buffer. The buffer is emptied when the operand is read, and it is invalidated when a newer write to the same register commits.

Top module: `shreg_store`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_valid`, `rd_pf_hit` and `wb_stall` are all 0, and no prefetched operand is held.
- R2: A read request in cycle t produces `rd_valid`=1 in cycle t+1 with the register's value on `rd_data`. A cycle with no read request gives `rd_valid`=0 in the next cycle.
- R3: The write-back queue holds 4 entries. `wb_stall` is 1 exactly when all 4 are occupied. A write presented while `wb_stall` is 1 is dropped and never changes any register.
- R4: A read of a register that has one or more writes waiting in the queue returns the value of the most recently accepted of those writes.
- R5: Queued writes commit oldest first, at most one per cycle. The oldest entry commits only in a cycle in which its bank is not read. While every cycle reads its bank, the queue does not drain. In the first cycle without such a read, it commits.
- R6: A write accepted in cycle t is seen by reads issued in cycle t+1 or later. A read of the same register issued in cycle t returns the earlier value.
- R7: `pf_accepted` is combinational. It is 1 when `pf_req` is 1, unless the same cycle's operand read needs that very bank from storage; in that case the prefetch is refused.
- R8: After an accepted prefetch, a read of the same bank and index (with no queued write to it) returns the fetched value with `rd_pf_hit`=1 and empties the buffer. A repeat read then has `rd_pf_hit`=0.
- R9: When a write to the buffered register commits, the buffer is invalidated. A later read returns the new value with `rd_pf_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Operand read request |
| rd_bank | input | 4 | Bank of the operand read |
| rd_idx | input | 7 | Register index within the bank |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | 32 | Read response data |
| rd_pf_hit | output | 1 | Response was served from the prefetch buffer |
| pf_req | input | 1 | Early fetch request for the next instruction's operand |
| pf_bank | input | 4 | Bank of the early fetch |
| pf_idx | input | 7 | Register index of the early fetch |
| pf_accepted | output | 1 | Early fetch taken this cycle |
| wb_req | input | 1 | ALU result write request |
| wb_bank | input | 4 | Target bank of the result |
| wb_idx | input | 7 | Target register index |
| wb_data | input | 32 | Result value |
| wb_stall | output | 1 | Queue full; writes are dropped while high |

## Verification
The checker assumes that reset is applied from time zero and that all request inputs are 0 or 1, never unknown. It also assumes the ALU honours `wb_stall`, except where a write is offered on purpose to show that it is dropped. The bench changes inputs only on falling edges and reads the combinational `pf_accepted` and `wb_stall` just after it drives them. Every register it checks has been written first, so expected values come from a shadow copy of accepted writes and never from uninitialised storage. Bank clashes are created on purpose: the bench keeps reading one bank while writes aimed at that bank pile up.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
    parameter int NUM_BANKS     = 16;
    parameter int REGS_PER_BANK = 128;
    parameter int DATA_W        = 32;
    parameter int WBQ_DEPTH     = 4;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = $clog2(REGS_PER_BANK);
    localparam int CNT_W  = $clog2(WBQ_DEPTH + 1);
    localparam int PTR_W  = (WBQ_DEPTH > 1) ? $clog2(WBQ_DEPTH) : 1;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [IDX_W-1:0]  idx;
    } reg_tag_t;

    typedef struct packed {
        reg_tag_t          tag;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(WBQ_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic bank_clash(input logic busy, input reg_tag_t a,
                                        input logic [BANK_W-1:0] b);
        return busy && (a.bank == b);
    endfunction
endpackage

// File: rtl/shreg_wbq.sv
`timescale 1ns/1ps
module shreg_wbq
    import shreg_pkg::*;
#(
    parameter int NUM_LOOK = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push,
    input  wb_entry_t                        push_entry,
    input  logic                             pop,
    output logic                             full,
    output logic                             empty,
    output wb_entry_t                        head,
    output logic [CNT_W-1:0]                 count,
    input  reg_tag_t [NUM_LOOK-1:0]          look_tag,
    output logic [NUM_LOOK-1:0]              look_hit,
    output logic [NUM_LOOK-1:0][DATA_W-1:0]  look_data
);
    wb_entry_t        slots [WBQ_DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    assign full  = (count == CNT_W'(WBQ_DEPTH));
    assign empty = (count == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    // Newest matching entry wins: scan oldest to newest, later hits overwrite.
    for (genvar lk = 0; lk < NUM_LOOK; lk++) begin : g_look
        logic              hit;
        logic [DATA_W-1:0] val;
        always_comb begin
            hit = 1'b0;
            val = '0;
            for (int i = 0; i < WBQ_DEPTH; i++) begin
                int s;
                s = (int'(rd_ptr) + i) % WBQ_DEPTH;
                if ((CNT_W'(i) < count) && (slots[s].tag == look_tag[lk])) begin
                    hit = 1'b1;
                    val = slots[s].data;
                end
            end
        end
        assign look_hit[lk]  = hit;
        assign look_data[lk] = val;
    end
endmodule

// File: rtl/shreg_banks.sv
`timescale 1ns/1ps
module shreg_banks
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rd0_en,
    input  reg_tag_t          rd0_tag,
    output logic [DATA_W-1:0] rd0_data,
    input  logic              rd1_en,
    input  reg_tag_t          rd1_tag,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  wb_entry_t         wr_entry
);
    logic [DATA_W-1:0] bank_q [NUM_BANKS];

    // One read index and one write per bank each cycle; the top keeps
    // the two read ports on distinct banks whenever both use storage.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] cells [REGS_PER_BANK];
        logic [IDX_W-1:0]  ridx;

        always_comb begin
            if (rd1_en && (rd1_tag.bank == BANK_W'(b)))
                ridx = rd1_tag.idx;
            else
                ridx = rd0_tag.idx;
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_entry.tag.bank == BANK_W'(b)))
                cells[wr_entry.tag.idx] <= wr_entry.data;
        end

        assign bank_q[b] = cells[ridx];
    end

    always_comb begin
        rd0_data = rd0_en ? bank_q[rd0_tag.bank] : '0;
        rd1_data = bank_q[rd1_tag.bank];
    end
endmodule

// File: rtl/shreg_pfbuf.sv
`timescale 1ns/1ps
module shreg_pfbuf
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  reg_tag_t          load_tag,
    input  logic [DATA_W-1:0] load_data,
    input  logic              consume,
    input  logic              commit,
    input  reg_tag_t          commit_tag,
    input  reg_tag_t          look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] held_data,
    output logic              held_valid,
    output reg_tag_t          held_tag
);
    assign look_hit = held_valid && (held_tag == look_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_tag   <= '0;
            held_data  <= '0;
        end else if (load) begin
            held_valid <= 1'b1;
            held_tag   <= load_tag;
            held_data  <= load_data;
        end else if (consume || (commit && (commit_tag == held_tag))) begin
            held_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/shreg_store.sv
`timescale 1ns/1ps
module shreg_store
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_pf_hit,
    input  logic              pf_req,
    input  logic [BANK_W-1:0] pf_bank,
    input  logic [IDX_W-1:0]  pf_idx,
    output logic              pf_accepted,
    input  logic              wb_req,
    input  logic [BANK_W-1:0] wb_bank,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    output logic              wb_stall
);
    reg_tag_t                   rd_tag, pf_tag;
    wb_entry_t                  push_entry, q_head;
    logic                       q_full, q_empty, push, commit;
    logic [CNT_W-1:0]           q_count;
    logic [1:0]                 q_hit;
    logic [1:0][DATA_W-1:0]     q_data;
    logic                       pb_hit, pb_valid, pf_load;
    reg_tag_t                   pb_tag;
    logic [DATA_W-1:0]          pb_data;
    logic                       rd_from_q, rd_from_pb, rd_uses_bank, pf_uses_bank;
    logic [DATA_W-1:0]          bank_rd, bank_pf, pf_value;

    assign rd_tag     = '{bank: rd_bank, idx: rd_idx};
    assign pf_tag     = '{bank: pf_bank, idx: pf_idx};
    assign push_entry = '{tag: '{bank: wb_bank, idx: wb_idx}, data: wb_data};

    // Source selection for the operand read: queue, then prefetch buffer, then bank.
    assign rd_from_q    = rd_req && q_hit[0];
    assign rd_from_pb   = rd_req && !q_hit[0] && pb_hit;
    assign rd_uses_bank = rd_req && !q_hit[0] && !pb_hit;

    assign pf_accepted  = pf_req && !bank_clash(rd_uses_bank, rd_tag, pf_bank);
    assign pf_uses_bank = pf_accepted && !q_hit[1];
    assign pf_load      = pf_accepted;
    assign pf_value     = q_hit[1] ? q_data[1] : bank_pf;

    // Reads own the bank port; the queue head waits for a free cycle.
    assign commit = !q_empty
                 && !bank_clash(rd_uses_bank, rd_tag, q_head.tag.bank)
                 && !bank_clash(pf_uses_bank, pf_tag, q_head.tag.bank);
    assign push     = wb_req && !q_full;
    assign wb_stall = q_full;

    shreg_wbq #(.NUM_LOOK(2)) u_wbq (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (push_entry),
        .pop        (commit),
        .full       (q_full),
        .empty      (q_empty),
        .head       (q_head),
        .count      (q_count),
        .look_tag   ({pf_tag, rd_tag}),
        .look_hit   (q_hit),
        .look_data  (q_data)
    );

    shreg_banks u_banks (
        .clk      (clk),
        .rd0_en   (rd_uses_bank),
        .rd0_tag  (rd_tag),
        .rd0_data (bank_rd),
        .rd1_en   (pf_uses_bank),
        .rd1_tag  (pf_tag),
        .rd1_data (bank_pf),
        .wr_en    (commit),
        .wr_entry (q_head)
    );

    shreg_pfbuf u_pfbuf (
        .clk        (clk),
        .rst        (rst),
        .load       (pf_load),
        .load_tag   (pf_tag),
        .load_data  (pf_value),
        .consume    (rd_from_pb),
        .commit     (commit),
        .commit_tag (q_head.tag),
        .look_tag   (rd_tag),
        .look_hit   (pb_hit),
        .held_data  (pb_data),
        .held_valid (pb_valid),
        .held_tag   (pb_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_pf_hit <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid  <= rd_req;
            rd_pf_hit <= rd_from_pb;
            if (rd_from_q)       rd_data <= q_data[0];
            else if (rd_from_pb) rd_data <= pb_data;
            else if (rd_req)     rd_data <= bank_rd;
        end
    end
endmodule

// File: rtl/shreg_store_chk.sv
`timescale 1ns/1ps
module shreg_store_chk
    import shreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              rd_pf_hit,
    input logic              pf_req,
    input logic              pf_accepted,
    input logic              wb_stall,
    input logic              commit,
    input logic              push,
    input logic [CNT_W-1:0]  q_count,
    input reg_tag_t          head_tag,
    input logic              rd_uses_bank,
    input reg_tag_t          rd_tag,
    input logic              pf_valid,
    input reg_tag_t          pf_tag,
    input logic              pf_load
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_pf_hit && !wb_stall && !pf_valid));

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(WBQ_DEPTH));

    a_r3_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        (wb_stall && !commit) |=> $stable(q_count));

    a_r5_read_wins: assert property (@(posedge clk) disable iff (rst)
        commit |-> !(rd_uses_bank && (rd_tag.bank == head_tag.bank)));

    a_r5_one_commit_step: assert property (@(posedge clk) disable iff (rst)
        (commit && !push) |=> (q_count == $past(q_count) - 1'b1));

    a_r7_pf_needs_req: assert property (@(posedge clk) disable iff (rst)
        pf_accepted |-> pf_req);

    a_r8_hit_needs_buffer: assert property (@(posedge clk) disable iff (rst)
        rd_pf_hit |-> $past(pf_valid));

    a_r9_commit_invalidates: assert property (@(posedge clk) disable iff (rst)
        (commit && pf_valid && (head_tag == pf_tag) && !pf_load) |=> !pf_valid);
endmodule

bind shreg_store shreg_store_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .rd_pf_hit    (rd_pf_hit),
    .pf_req       (pf_req),
    .pf_accepted  (pf_accepted),
    .wb_stall     (wb_stall),
    .commit       (commit),
    .push         (push),
    .q_count      (q_count),
    .head_tag     (q_head.tag),
    .rd_uses_bank (rd_uses_bank),
    .rd_tag       (rd_tag),
    .pf_valid     (pb_valid),
    .pf_tag       (pb_tag),
    .pf_load      (pf_load)
);

// File: tb/shreg_store_bench.sv
`timescale 1ns/1ps
module shreg_store_bench;
    import shreg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req = 0, pf_req = 0, wb_req = 0;
    logic [BANK_W-1:0] rd_bank = '0, pf_bank = '0, wb_bank = '0;
    logic [IDX_W-1:0]  rd_idx = '0, pf_idx = '0, wb_idx = '0;
    logic [DATA_W-1:0] wb_data = '0;
    logic rd_valid, rd_pf_hit, pf_accepted, wb_stall;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DATA_W-1:0] shadow [NUM_BANKS*REGS_PER_BANK];
    logic [DATA_W-1:0] exp_rd;
    logic pf_seen, stall_seen;

    always #5 clk = ~clk;

    shreg_store u_shreg_store (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_pf_hit(rd_pf_hit),
        .pf_req(pf_req), .pf_bank(pf_bank), .pf_idx(pf_idx), .pf_accepted(pf_accepted),
        .wb_req(wb_req), .wb_bank(wb_bank), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_stall(wb_stall)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: inputs driven at a falling edge, results seen at the next one.
    task automatic cyc(input bit rq, input int rb, input int ri,
                       input bit pq, input int pb, input int pi,
                       input bit wq, input int wbk, input int wi, input logic [31:0] wd);
        rd_req = rq; rd_bank = BANK_W'(rb); rd_idx = IDX_W'(ri);
        pf_req = pq; pf_bank = BANK_W'(pb); pf_idx = IDX_W'(pi);
        wb_req = wq; wb_bank = BANK_W'(wbk); wb_idx = IDX_W'(wi); wb_data = wd;
        #1;
        pf_seen = pf_accepted;
        stall_seen = wb_stall;
        if (rq) exp_rd = shadow[rb*REGS_PER_BANK + ri];
        @(posedge clk);
        if (wq && !stall_seen) shadow[wbk*REGS_PER_BANK + wi] = wd;
        @(negedge clk);
        rd_req = 0; pf_req = 0; wb_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0,0,0, 0,0,0, 0,0,0, 32'h0);
    endtask

    task automatic wr(input int b, input int i, input logic [31:0] d);
        cyc(0,0,0, 0,0,0, 1,b,i,d);
    endtask

    task automatic rd_check(input int b, input int i, input bit exp_hit, input string req);
        cyc(1,b,i, 0,0,0, 0,0,0, 32'h0);
        check(rd_valid === 1'b1, req, {31'b0, rd_valid}, 32'h1);
        check(rd_data === exp_rd, req, rd_data, exp_rd);
        check(rd_pf_hit === exp_hit, req, {31'b0, rd_pf_hit}, {31'b0, exp_hit});
    endtask

    task automatic t_reset;
        check(rd_valid === 1'b0, "R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        check(wb_stall === 1'b0, "R1 wb_stall", {31'b0, wb_stall}, 32'h0);
        check(rd_pf_hit === 1'b0, "R1 rd_pf_hit", {31'b0, rd_pf_hit}, 32'h0);
    endtask

    task automatic t_basic;
        wr(2, 5, 32'hA5A5_0001);
        idle(6);
        rd_check(2, 5, 0, "R2 basic read");
        idle(1);
        check(rd_valid === 1'b0, "R2 idle no valid", {31'b0, rd_valid}, 32'h0);
    endtask

    task automatic t_same_cycle;
        wr(2, 6, 32'hC0C0_0002);
        idle(6);
        cyc(1,2,6, 0,0,0, 1,2,6, 32'hB0B0_0003);
        check(rd_data === 32'hC0C0_0002, "R6 same-cycle read sees old", rd_data, 32'hC0C0_0002);
        rd_check(2, 6, 0, "R6 next-cycle read sees new");
        check(rd_data === 32'hB0B0_0003, "R4 forwarded value", rd_data, 32'hB0B0_0003);
    endtask

    task automatic t_forward_newest;
        wr(7, 0, 32'h7000_0000);
        idle(6);
        cyc(1,7,0, 0,0,0, 1,7,1, 32'h1111_1111);
        cyc(1,7,0, 0,0,0, 1,7,1, 32'h2222_2222);
        cyc(1,7,0, 0,0,0, 1,7,2, 32'h3333_3333);
        rd_check(7, 1, 0, "R4 newest queued value");
        check(rd_data === 32'h2222_2222, "R4 newest of two", rd_data, 32'h2222_2222);
        idle(6);
        rd_check(7, 2, 0, "R5 drained value");
    endtask

    task automatic t_stall;
        wr(3, 100, 32'h3100_0000);
        wr(3, 10, 32'h3010_AAAA);
        idle(6);
        for (int i = 0; i < WBQ_DEPTH; i++)
            cyc(1,3,100, 0,0,0, 1,3,20+i, 32'h3020_0000 + i);
        check(rd_data === 32'h3100_0000, "R5 read served under clash", rd_data, 32'h3100_0000);
        check(wb_stall === 1'b1, "R3 stall at 4 pending", {31'b0, wb_stall}, 32'h1);
        cyc(1,3,100, 0,0,0, 1,3,10, 32'hDEAD_BEEF);
        check(stall_seen === 1'b1, "R3 write offered during stall", {31'b0, stall_seen}, 32'h1);
        for (int i = 0; i < 2; i++) cyc(1,3,100, 0,0,0, 0,0,0, 32'h0);
        check(wb_stall === 1'b1, "R5 read wins, queue held", {31'b0, wb_stall}, 32'h1);
        idle(1);
        check(wb_stall === 1'b0, "R5 drains when bank free", {31'b0, wb_stall}, 32'h0);
        idle(6);
        rd_check(3, 10, 0, "R3 dropped write had no effect");
        check(rd_data === 32'h3010_AAAA, "R3 register kept", rd_data, 32'h3010_AAAA);
        for (int i = 0; i < WBQ_DEPTH; i++) rd_check(3, 20+i, 0, "R5 fifo commit");
    endtask

    task automatic t_prefetch;
        wr(5, 1, 32'h5001_0000);
        wr(6, 2, 32'h6002_0000);
        idle(6);
        cyc(1,5,1, 1,5,2, 0,0,0, 32'h0);
        check(pf_seen === 1'b0, "R7 refused on bank clash", {31'b0, pf_seen}, 32'h0);
        cyc(1,5,1, 1,6,2, 0,0,0, 32'h0);
        check(pf_seen === 1'b1, "R7 accepted on other bank", {31'b0, pf_seen}, 32'h1);
        rd_check(6, 2, 1, "R8 served from buffer");
        rd_check(6, 2, 0, "R8 buffer consumed");
    endtask

    task automatic t_invalidate;
        wr(8, 3, 32'h8003_0001);
        idle(6);
        cyc(0,0,0, 1,8,3, 0,0,0, 32'h0);
        check(pf_seen === 1'b1, "R7 accepted without read", {31'b0, pf_seen}, 32'h1);
        wr(8, 3, 32'h8003_0002);
        idle(6);
        rd_check(8, 3, 0, "R9 commit invalidates buffer");
        check(rd_data === 32'h8003_0002, "R9 new value", rd_data, 32'h8003_0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_same_cycle();
        t_forward_newest();
        t_stall();
        t_prefetch();
        t_invalidate();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule